// File: doc/BRIEF.md
# Page Translation Buffer with Access Rights

This block is a small direct-mapped translation buffer that sits in front of a memory pipeline. Every lookup presents a virtual address, the kind of access (instruction fetch, load or store) and whether the requester runs at user level. One cycle later the block answers with one of three results: hit, miss or protection fault. On a hit it also returns the physical address, the per-page cache-disable and write-through attributes, and the page's accessed and dirty state after this access has been applied.

Entries are installed by an external page-walk agent through a one-cycle fill port. A global invalidate input drops every entry at once. Each entry records which page it maps, the frame number and seven attribute flags. The block checks the write, privilege and execute rights itself and keeps the accessed and dirty flags up to date. Walking the page tables is left to the agent.

Top module: `ptl_tlb`

## Requirements
- R1: After reset the response valid output is low, and every entry is empty, so the first lookup of any address reports a miss.
- R2: A lookup with `req_valid` high is answered exactly one clock later with `rsp_valid` high. A cycle without a lookup gives `rsp_valid` low one clock later. Access kind codes are 0 fetch, 1 load and 2 store; code 3 behaves as a load. Result codes are 0 hit, 1 miss and 2 fault.
- R3: The entry slot is the virtual page number modulo `ENTRIES`, and the rest of the page number is kept as a tag. On a hit the physical address is the stored frame number placed above the unchanged page offset. Two pages that share a slot displace each other.
- R4: A lookup whose slot is empty or holds a different page reports a miss. On a miss or a fault, the physical address, cache-disable, write-through, dirty and accessed outputs are all zero.
- R5: Flag bit 0 means writable. A store that hits a page with bit 0 clear reports a fault.
- R6: Flag bit 1 means user-accessible. Any access with `req_user` high that hits a page with bit 1 clear reports a fault.
- R7: Flag bit 2 means no-execute. A fetch that hits a page with bit 2 set reports a fault.
- R8: A miss takes precedence over a rights violation. A lookup that maps to a slot holding another page reports a miss, even when that stale entry's flags would forbid the access.
- R9: Flag bit 6 is accessed and bit 5 is dirty. A lookup that hits without a fault sets accessed, and a store that hits also sets dirty. `rsp_accessed` and `rsp_dirty` report the flags with this access applied. A faulting lookup changes no flag.
- R10: On a hit, `rsp_nocache` carries flag bit 3 and `rsp_wthru` carries flag bit 4 of the matching entry.
- R11: `inv_all` empties every entry at the end of its cycle. A fill in the same cycle is discarded, and a lookup in that cycle still sees the entries as they were.
- R12: A fill writes one slot and replaces whatever was there. A lookup in the same cycle as a fill sees the contents from before the fill. During a fill cycle the flag update of a concurrent hit is dropped, although the response still reports the updated values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | VPN_W+OFF_W | Virtual address |
| req_kind | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| req_user | input | 1 | Request at user privilege |
| fill_en | input | 1 | Install an entry |
| fill_vpn | input | VPN_W | Page number of the installed entry |
| fill_pfn | input | PFN_W | Frame number of the installed entry |
| fill_flags | input | 7 | Attribute flags of the installed entry |
| inv_all | input | 1 | Empty every entry |
| rsp_valid | output | 1 | Response present |
| rsp_status | output | 2 | 0 hit, 1 miss, 2 fault |
| rsp_paddr | output | PFN_W+OFF_W | Physical address on a hit |
| rsp_nocache | output | 1 | Page is uncacheable |
| rsp_wthru | output | 1 | Page uses write-through |
| rsp_dirty | output | 1 | Dirty flag after this access |
| rsp_accessed | output | 1 | Accessed flag after this access |

## Verification
The hardest situations to reach from the ports are collisions inside a single cycle: a fill that lands alongside a lookup, which drops that lookup's flag update, and a lookup that maps to a slot still holding a different valid page whose flags would fault. The random phase draws page numbers from only three tags per slot, fills about one cycle in four and often issues a lookup in the same cycle. Aliasing, same-cycle fills and stale-entry misses therefore occur many times. Directed sequences before the random phase set up each of these cases on purpose and also check that a faulting store leaves the dirty flag clear.

// File: rtl/ptl_pkg.sv
package ptl_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    RES_HIT   = 2'd0,
    RES_MISS  = 2'd1,
    RES_FAULT = 2'd2
  } res_e;

  localparam int FLG_W   = 7;
  localparam int F_WR    = 0;
  localparam int F_USR   = 1;
  localparam int F_NX    = 2;
  localparam int F_CD    = 3;
  localparam int F_WT    = 4;
  localparam int F_DIRTY = 5;
  localparam int F_ACC   = 6;
endpackage

// File: rtl/ptl_split.sv
module ptl_split #(
  parameter int VPN_W   = 20,
  parameter int ENTRIES = 40,
  parameter int IDX_W   = 6,
  parameter int TAG_W   = 15
) (
  input  logic [VPN_W-1:0] vpn,
  output logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] tag
);
  localparam bit POW2 = (ENTRIES & (ENTRIES - 1)) == 0;

  generate
    if (POW2 && ENTRIES > 1) begin : g_slice
      localparam int SH = $clog2(ENTRIES);
      logic [VPN_W-1:0] hi;
      assign idx = IDX_W'(vpn[SH-1:0]);
      assign hi  = vpn >> SH;
      assign tag = TAG_W'(hi);
    end else begin : g_divide
      logic [VPN_W-1:0] rem;
      logic [VPN_W-1:0] quo;
      assign rem = vpn % VPN_W'(ENTRIES);
      assign quo = vpn / VPN_W'(ENTRIES);
      assign idx = IDX_W'(rem);
      assign tag = TAG_W'(quo);
    end
  endgenerate
endmodule

// File: rtl/ptl_rights.sv
module ptl_rights
  import ptl_pkg::*;
(
  input  logic [1:0]       kind,
  input  logic             user,
  input  logic [FLG_W-1:0] flags,
  output logic             fault
);
  logic no_write, no_user, no_exec;

  always_comb begin
    no_write = (kind == ACC_STORE) && !flags[F_WR];
    no_user  = user && !flags[F_USR];
    no_exec  = (kind == ACC_FETCH) && flags[F_NX];
    fault    = no_write || no_user || no_exec;
  end
endmodule

// File: rtl/ptl_array.sv
module ptl_array #(
  parameter int ENTRIES = 40,
  parameter int IDX_W   = 6,
  parameter int TAG_W   = 15,
  parameter int PFN_W   = 20,
  parameter int FW      = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inv,
  input  logic             wr_en,
  input  logic             wr_set_valid,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PFN_W-1:0] wr_pfn,
  input  logic [FW-1:0]    wr_flags,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [PFN_W-1:0] rd_pfn,
  output logic [FW-1:0]    rd_flags
);
  logic [TAG_W-1:0] tag_m [ENTRIES];
  logic [PFN_W-1:0] pfn_m [ENTRIES];
  logic [FW-1:0]    flg_m [ENTRIES];
  logic [ENTRIES-1:0] valid_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_m[wr_idx] <= wr_tag;
      pfn_m[wr_idx] <= wr_pfn;
      flg_m[wr_idx] <= wr_flags;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || inv) begin
      valid_q <= '0;
    end else if (wr_en && wr_set_valid) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_m[rd_idx];
  assign rd_pfn   = pfn_m[rd_idx];
  assign rd_flags = flg_m[rd_idx];
endmodule

// File: rtl/ptl_tlb.sv
module ptl_tlb
  import ptl_pkg::*;
#(
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int ENTRIES = 40
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [VPN_W+OFF_W-1:0] req_vaddr,
  input  logic [1:0]             req_kind,
  input  logic                   req_user,
  input  logic                   fill_en,
  input  logic [VPN_W-1:0]       fill_vpn,
  input  logic [PFN_W-1:0]       fill_pfn,
  input  logic [6:0]             fill_flags,
  input  logic                   inv_all,
  output logic                   rsp_valid,
  output logic [1:0]             rsp_status,
  output logic [PFN_W+OFF_W-1:0] rsp_paddr,
  output logic                   rsp_nocache,
  output logic                   rsp_wthru,
  output logic                   rsp_dirty,
  output logic                   rsp_accessed
);
  localparam int VA_W  = VPN_W + OFF_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int TAG_W = VPN_W - $clog2(ENTRIES) + 1;

  logic [VPN_W-1:0] lk_vpn;
  logic [IDX_W-1:0] lk_idx, f_idx;
  logic [TAG_W-1:0] lk_tag, f_tag;
  logic             rd_valid;
  logic [TAG_W-1:0] rd_tag;
  logic [PFN_W-1:0] rd_pfn;
  logic [FLG_W-1:0] rd_flags;
  logic             rights_fault;
  logic             tag_ok, hit;
  res_e             res;
  logic [FLG_W-1:0] upd_flags;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [TAG_W-1:0] wr_tag;
  logic [PFN_W-1:0] wr_pfn;
  logic [FLG_W-1:0] wr_flags;

  assign lk_vpn = req_vaddr[VA_W-1:OFF_W];

  ptl_split #(.VPN_W(VPN_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_split_lk (
    .vpn(lk_vpn), .idx(lk_idx), .tag(lk_tag)
  );

  ptl_split #(.VPN_W(VPN_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_split_fill (
    .vpn(fill_vpn), .idx(f_idx), .tag(f_tag)
  );

  ptl_array #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W), .PFN_W(PFN_W), .FW(FLG_W)) u_array (
    .clk(clk), .rst(rst), .inv(inv_all),
    .wr_en(wr_en), .wr_set_valid(fill_en), .wr_idx(wr_idx),
    .wr_tag(wr_tag), .wr_pfn(wr_pfn), .wr_flags(wr_flags),
    .rd_idx(lk_idx), .rd_valid(rd_valid), .rd_tag(rd_tag),
    .rd_pfn(rd_pfn), .rd_flags(rd_flags)
  );

  ptl_rights u_rights (
    .kind(req_kind), .user(req_user), .flags(rd_flags), .fault(rights_fault)
  );

  // Miss is decided before rights: a stale entry never yields a fault.
  always_comb begin
    tag_ok = rd_valid && (rd_tag == lk_tag);
    if (!tag_ok)          res = RES_MISS;
    else if (rights_fault) res = RES_FAULT;
    else                   res = RES_HIT;
    hit = req_valid && (res == RES_HIT);
    upd_flags = rd_flags;
    upd_flags[F_ACC] = 1'b1;
    if (req_kind == ACC_STORE) upd_flags[F_DIRTY] = 1'b1;
  end

  // Single write port: a fill takes it, otherwise a hit writes back flags.
  always_comb begin
    wr_en    = fill_en || hit;
    wr_idx   = fill_en ? f_idx      : lk_idx;
    wr_tag   = fill_en ? f_tag      : rd_tag;
    wr_pfn   = fill_en ? fill_pfn   : rd_pfn;
    wr_flags = fill_en ? fill_flags : upd_flags;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_status   <= RES_MISS;
      rsp_paddr    <= '0;
      rsp_nocache  <= 1'b0;
      rsp_wthru    <= 1'b0;
      rsp_dirty    <= 1'b0;
      rsp_accessed <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_status   <= res;
        rsp_paddr    <= hit ? {rd_pfn, req_vaddr[OFF_W-1:0]} : '0;
        rsp_nocache  <= hit && rd_flags[F_CD];
        rsp_wthru    <= hit && rd_flags[F_WT];
        rsp_dirty    <= hit && upd_flags[F_DIRTY];
        rsp_accessed <= hit;
      end
    end
  end

  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid));

  p_hit_offset_r3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == RES_HIT) |->
      rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]));

  p_nonhit_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status != RES_HIT) |->
      (rsp_paddr == '0 && !rsp_nocache && !rsp_wthru && !rsp_dirty && !rsp_accessed));

  p_hit_accessed_r9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == RES_HIT) |-> rsp_accessed);

  p_store_dirty_r9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == RES_HIT && $past(req_kind) == ACC_STORE) |-> rsp_dirty);

  p_inv_empties_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && $past(inv_all)) |=> (rsp_status == RES_MISS));
endmodule

// File: tb/ptl_tlb_tb.sv
`timescale 1ns/1ps
module ptl_tlb_tb;
  localparam int VPN_W = 20;
  localparam int PFN_W = 20;
  localparam int OFF_W = 12;
  localparam int ENTRIES = 40;
  localparam int VA_W = VPN_W + OFF_W;
  localparam int PA_W = PFN_W + OFF_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [VA_W-1:0] req_vaddr = '0;
  logic [1:0] req_kind = '0;
  logic req_user = 1'b0;
  logic fill_en = 1'b0;
  logic [VPN_W-1:0] fill_vpn = '0;
  logic [PFN_W-1:0] fill_pfn = '0;
  logic [6:0] fill_flags = '0;
  logic inv_all = 1'b0;
  logic rsp_valid;
  logic [1:0] rsp_status;
  logic [PA_W-1:0] rsp_paddr;
  logic rsp_nocache, rsp_wthru, rsp_dirty, rsp_accessed;

  always #4 clk = ~clk;

  ptl_tlb #(.VPN_W(VPN_W), .PFN_W(PFN_W), .OFF_W(OFF_W), .ENTRIES(ENTRIES)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .req_user(req_user), .fill_en(fill_en),
    .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_flags(fill_flags),
    .inv_all(inv_all), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .rsp_paddr(rsp_paddr), .rsp_nocache(rsp_nocache), .rsp_wthru(rsp_wthru),
    .rsp_dirty(rsp_dirty), .rsp_accessed(rsp_accessed)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic m_val [ENTRIES];
  logic [VPN_W-1:0] m_vpn [ENTRIES];
  logic [PFN_W-1:0] m_pfn [ENTRIES];
  logic [6:0] m_flg [ENTRIES];

  logic [PA_W+6:0] exp_vec;
  bit exp_live = 1'b0;
  string exp_tag;

  function automatic logic [PA_W+6:0] pack_rsp(logic v, logic [1:0] st, logic [PA_W-1:0] pa,
                                               logic cd, logic wt, logic d, logic a);
    return {v, st, pa, cd, wt, d, a};
  endfunction

  task automatic check_prev();
    logic [PA_W+6:0] act;
    if (!exp_live) return;
    act = pack_rsp(rsp_valid, rsp_status, rsp_paddr, rsp_nocache, rsp_wthru, rsp_dirty, rsp_accessed);
    checks++;
    if (act !== exp_vec) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", exp_tag, act, exp_vec);
    end
  endtask

  // One cycle: check the previous response, drive new inputs, predict and update the model.
  task automatic step(input logic rv, input logic [VPN_W-1:0] vpn, input logic [OFF_W-1:0] off,
                      input logic [1:0] kind, input logic usr,
                      input logic fe, input logic [VPN_W-1:0] fv, input logic [PFN_W-1:0] fp,
                      input logic [6:0] ff, input logic inv, input string tag);
    int idx;
    int fidx;
    logic [1:0] st;
    logic [PA_W-1:0] pa;
    logic cd, wt, d, a, ishit;
    string t;
    @(negedge clk);
    check_prev();
    req_valid = rv; req_vaddr = {vpn, off}; req_kind = kind; req_user = usr;
    fill_en = fe; fill_vpn = fv; fill_pfn = fp; fill_flags = ff; inv_all = inv;
    idx = int'(vpn % VPN_W'(ENTRIES));
    st = 2'd0; pa = '0; cd = 0; wt = 0; d = 0; a = 0; ishit = 0; t = "R2";
    if (rv) begin
      if (!m_val[idx]) begin
        st = 2'd1; t = "R4";
      end else if (m_vpn[idx] != vpn) begin
        st = 2'd1; t = "R3/R8 alias miss";
      end else if (kind == 2'd2 && !m_flg[idx][0]) begin
        st = 2'd2; t = "R5";
      end else if (usr && !m_flg[idx][1]) begin
        st = 2'd2; t = "R6";
      end else if (kind == 2'd0 && m_flg[idx][2]) begin
        st = 2'd2; t = "R7";
      end else begin
        ishit = 1; st = 2'd0; t = "R3/R9/R10 hit";
        pa = {m_pfn[idx], off}; cd = m_flg[idx][3]; wt = m_flg[idx][4];
        a = 1'b1; d = m_flg[idx][5] | (kind == 2'd2);
      end
    end
    exp_vec = pack_rsp(rv, rv ? st : rsp_status, rv ? pa : rsp_paddr, rv ? cd : rsp_nocache,
                       rv ? wt : rsp_wthru, rv ? d : rsp_dirty, rv ? a : rsp_accessed);
    exp_live = 1'b1;
    exp_tag = (tag != "") ? tag : t;
    if (inv) begin
      for (int i = 0; i < ENTRIES; i++) m_val[i] = 1'b0;
    end else if (fe) begin
      fidx = int'(fv % VPN_W'(ENTRIES));
      m_val[fidx] = 1'b1; m_vpn[fidx] = fv; m_pfn[fidx] = fp; m_flg[fidx] = ff;
    end else if (ishit) begin
      m_flg[idx][6] = 1'b1;
      if (kind == 2'd2) m_flg[idx][5] = 1'b1;
    end
  endtask

  task automatic look(input logic [VPN_W-1:0] vpn, input logic [1:0] kind, input logic usr,
                      input string tag);
    step(1'b1, vpn, OFF_W'(12'h5A3), kind, usr, 1'b0, '0, '0, '0, 1'b0, tag);
  endtask

  task automatic fill(input logic [VPN_W-1:0] fv, input logic [PFN_W-1:0] fp, input logic [6:0] ff);
    step(1'b0, '0, '0, 2'd1, 1'b0, 1'b1, fv, fp, ff, 1'b0, "R2 idle");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unused;
    for (int i = 0; i < ENTRIES; i++) begin
      m_val[i] = 1'b0; m_vpn[i] = '0; m_pfn[i] = '0; m_flg[i] = '0;
    end
    unused = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: outputs quiet out of reset, table empty
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: actual rsp_valid %b expected 0", rsp_valid);
    end
    look(20'd5, 2'd1, 1'b0, "R1 empty after reset");
    // R3/R9: install and hit
    fill(20'd5, 20'hABCDE, 7'h03);
    look(20'd5, 2'd1, 1'b1, "R3 translate, R9 accessed");
    look(20'd5, 2'd2, 1'b1, "R9 store sets dirty");
    look(20'd5, 2'd3, 1'b0, "R9 dirty kept, R2 kind 3 as load");
    // R3 aliasing, R5/R6/R7 faults, R10 attributes
    fill(20'd45, 20'h12345, 7'h00);
    look(20'd5, 2'd1, 1'b0, "R3 displaced by alias");
    look(20'd45, 2'd2, 1'b0, "R5 store to read-only");
    look(20'd45, 2'd1, 1'b1, "R6 user to supervisor page");
    fill(20'd7, 20'h0F0F0, 7'h1F);
    look(20'd7, 2'd0, 1'b0, "R7 fetch from no-exec");
    look(20'd7, 2'd1, 1'b1, "R10 cache attributes");
    look(20'd85, 2'd2, 1'b1, "R8 miss before rights");
    // R9: faulting store leaves flags alone
    fill(20'd9, 20'h00999, 7'h00);
    look(20'd9, 2'd2, 1'b0, "R5 fault");
    look(20'd9, 2'd1, 1'b0, "R9 fault left dirty clear");
    // R12: fill colliding with lookups
    fill(20'd10, 20'h0AAAA, 7'h03);
    step(1'b1, 20'd10, 12'h010, 2'd1, 1'b0, 1'b1, 20'd10, 20'h0BBBB, 7'h03, 1'b0, "R12 sees old content");
    look(20'd10, 2'd1, 1'b0, "R12 new content after fill");
    step(1'b1, 20'd10, 12'h020, 2'd2, 1'b0, 1'b1, 20'd11, 20'h0CCCC, 7'h03, 1'b0, "R12 store during fill");
    look(20'd10, 2'd1, 1'b0, "R12 dirty update dropped");
    // R11: invalidate with concurrent fill and lookup
    step(1'b1, 20'd7, 12'h000, 2'd1, 1'b0, 1'b1, 20'd12, 20'h0DDDD, 7'h03, 1'b1, "R11 lookup in invalidate cycle");
    look(20'd7, 2'd1, 1'b0, "R11 emptied");
    look(20'd12, 2'd1, 1'b0, "R11 fill discarded");
    look(20'd10, 2'd1, 1'b0, "R11 emptied");
    // Random phase
    for (int n = 0; n < 4000; n++) begin
      logic [VPN_W-1:0] v, fv;
      int r;
      v  = VPN_W'(($urandom % 3) * ENTRIES + ($urandom % ENTRIES));
      fv = VPN_W'(($urandom % 3) * ENTRIES + ($urandom % ENTRIES));
      r = $urandom % 100;
      step(($urandom % 4) != 0, v, OFF_W'($urandom), 2'($urandom), 1'($urandom),
           r < 25, fv, PFN_W'($urandom), 7'($urandom), r == 99, "");
    end
    step(1'b0, '0, '0, 2'd1, 1'b0, 1'b0, '0, '0, '0, 1'b0, "R2 idle");
    @(negedge clk);
    check_prev();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule